// File: doc/BRIEF.md
# Dual-Result Completion Output Stage

This block is the last pipeline stage of an execution unit whose answer is twice the width of a register, for instance the full product of two word-wide operands. It holds the low and the high word of that answer, together with one destination register tag, and offers each word on its own register-file write port. Each port has its own complete flag and its own tag. The high word goes to the supplied register number plus one.

Both complete flags are loaded together from the stage-valid bit when the stage advances. Each port's acknowledge then clears only its own flag, so the two words can drain in different cycles. While either word is still waiting, the stage raises a stall that holds the upstream pipeline and refuses new data. The stage can take new data in the same cycle in which its last pending word is acknowledged. The arithmetic and the opcode decoding sit upstream and are not part of this block.

Top module: `dual_result_stage`

## Requirements
- R1: While reset is asserted, and after it is released, both complete outputs and the stall output are 0.
- R2: When the stage is free (no stall) and `adv` is 1, the next clock edge loads `in_valid` into both complete flags and loads `lo_in`, `hi_in` and `tag_in` onto `lo_out`, `hi_out` and `tag_lo`.
- R3: `tag_hi` always equals `tag_lo` plus one, modulo 2^TAG_W, so tag 63 gives tag 0 at the default width.
- R4: An acknowledge on a port whose complete flag is 1 clears that flag at the next clock edge and leaves the other port's flag unchanged, unless the stage loads new data at that edge.
- R5: `stall` is 1 exactly when some port has its complete flag set and its acknowledge low in the current cycle.
- R6: While `stall` is 1, `adv` and the data inputs are ignored. Results and tags hold their values across the clock edge.
- R7: If the two acknowledges come in different cycles, the port not yet acknowledged keeps its complete flag, tag and word until its own acknowledge arrives.
- R8: If every pending word is acknowledged in the current cycle and `adv` is 1, new data loads at that edge, so a new result appears in back-to-back cycles.
- R9: An acknowledge on a port whose complete flag is 0 has no effect.
- R10: A load with `in_valid` 0 leaves both complete flags at 0, which inserts a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Upstream stage enable: offer the stage a new entry this cycle |
| in_valid | input | 1 | Stage-valid bit of the offered entry |
| tag_in | input | TAG_W | Destination register of the low word |
| lo_in | input | WORD_W | Low result word |
| hi_in | input | WORD_W | High result word |
| ack_lo | input | 1 | Low port write accepted this cycle |
| ack_hi | input | 1 | High port write accepted this cycle |
| cmp_lo | output | 1 | Low port holds a result to write |
| cmp_hi | output | 1 | High port holds a result to write |
| tag_lo | output | TAG_W | Destination of the low word |
| tag_hi | output | TAG_W | Destination of the high word (tag_lo + 1) |
| lo_out | output | WORD_W | Low result word |
| hi_out | output | WORD_W | High result word |
| stall | output | 1 | Hold the upstream pipeline |

## Verification
Loads and acknowledges show on the complete flags, tags and words one clock edge after the cycle in which they are driven. The stall output is combinational and follows the acknowledges in the same cycle. The bench drives inputs just after the falling edge. At the following falling edge it compares every output against a behavioural reference model that it updated at the rising edge between them. Directed sequences cover the tag wrap, split and joint acknowledges, stray acknowledges and bubbles at their due cycle. A long random run with the stub product checks the rest.

// File: rtl/drs_pkg.sv
package drs_pkg;
   localparam int unsigned NUM_PORTS = 2;
   typedef enum logic [0:0] {
      PORT_LO = 1'b0,
      PORT_HI = 1'b1
   } port_e;
endpackage

// File: rtl/drs_tag_next.sv
module drs_tag_next #(
   parameter int unsigned TAG_W = 6
) (
   input  logic [TAG_W-1:0] tag_base,
   output logic [TAG_W-1:0] tag_succ
);
   localparam logic [TAG_W-1:0] ONE = {{(TAG_W-1){1'b0}}, 1'b1};
   // wraps modulo 2^TAG_W by truncation
   assign tag_succ = tag_base + ONE;
endmodule

// File: rtl/drs_cmp_flag.sv
module drs_cmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_val,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (load)    flag <= load_val;
      else if (ack)     flag <= 1'b0;
   end
endmodule

// File: rtl/drs_word_hold.sv
module drs_word_hold #(
   parameter int unsigned W          = 64,
   parameter bit          RESET_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (RESET_DATA) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (en)  q <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (en) q <= d;
      end
   end
endmodule

// File: rtl/dual_result_stage.sv
module dual_result_stage #(
   parameter int unsigned WORD_W     = 64,
   parameter int unsigned TAG_W      = 6,
   parameter bit          RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              in_valid,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic [WORD_W-1:0] lo_in,
   input  logic [WORD_W-1:0] hi_in,
   input  logic              ack_lo,
   input  logic              ack_hi,
   output logic              cmp_lo,
   output logic              cmp_hi,
   output logic [TAG_W-1:0]  tag_lo,
   output logic [TAG_W-1:0]  tag_hi,
   output logic [WORD_W-1:0] lo_out,
   output logic [WORD_W-1:0] hi_out,
   output logic              stall
);
   import drs_pkg::*;

   localparam int unsigned NP = NUM_PORTS;

   if (WORD_W < 1) begin : g_bad_word
      $error("dual_result_stage: WORD_W must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dual_result_stage: TAG_W must be at least 1");
   end

   logic [NP-1:0] acks;
   logic [NP-1:0] flags;
   logic [NP-1:0] port_free;
   logic          take;

   assign acks[PORT_LO] = ack_lo;
   assign acks[PORT_HI] = ack_hi;

   // a port is free when empty or being drained this cycle
   assign port_free = ~flags | acks;
   assign stall     = ~&port_free;
   assign take      = adv & ~stall;

   for (genvar p = 0; p < NP; p++) begin : g_port
      drs_cmp_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (take),
         .load_val (in_valid),
         .ack      (acks[p]),
         .flag     (flags[p])
      );
   end

   assign cmp_lo = flags[PORT_LO];
   assign cmp_hi = flags[PORT_HI];

   drs_word_hold #(.W(WORD_W), .RESET_DATA(RESET_DATA)) u_lo (
      .clk (clk), .rst_n (rst_n), .en (take), .d (lo_in), .q (lo_out)
   );
   drs_word_hold #(.W(WORD_W), .RESET_DATA(RESET_DATA)) u_hi (
      .clk (clk), .rst_n (rst_n), .en (take), .d (hi_in), .q (hi_out)
   );
   drs_word_hold #(.W(TAG_W), .RESET_DATA(RESET_DATA)) u_tag (
      .clk (clk), .rst_n (rst_n), .en (take), .d (tag_in), .q (tag_lo)
   );

   drs_tag_next #(.TAG_W(TAG_W)) u_inc (
      .tag_base (tag_lo),
      .tag_succ (tag_hi)
   );
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned TAG_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv,
   input logic              in_valid,
   input logic              ack_lo,
   input logic              ack_hi,
   input logic              cmp_lo,
   input logic              cmp_hi,
   input logic [TAG_W-1:0]  tag_lo,
   input logic [TAG_W-1:0]  tag_hi,
   input logic [WORD_W-1:0] lo_out,
   input logic [WORD_W-1:0] hi_out,
   input logic              stall
);
   localparam logic [TAG_W-1:0] ONE = {{(TAG_W-1){1'b0}}, 1'b1};

   // R2
   load_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !stall) |=> (cmp_lo == $past(in_valid)) && (cmp_hi == $past(in_valid)));

   // R3
   tag_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_hi == tag_lo + ONE);

   // R4
   ack_clears_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_lo && ack_lo && !(adv && !stall)) |=> !cmp_lo);

   // R6
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(lo_out) && $stable(hi_out) && $stable(tag_lo));

   // R7
   hi_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hi && !ack_hi) |=> cmp_hi);

   // R5
   pending_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmp_lo && !ack_lo) || (cmp_hi && !ack_hi)) |-> stall);
endmodule

bind dual_result_stage drs_checker #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .adv (adv), .in_valid (in_valid),
   .ack_lo (ack_lo), .ack_hi (ack_hi), .cmp_lo (cmp_lo), .cmp_hi (cmp_hi),
   .tag_lo (tag_lo), .tag_hi (tag_hi), .lo_out (lo_out), .hi_out (hi_out),
   .stall (stall)
);

// File: tb/tb_dual_result_stage.sv
`timescale 1ns/1ps
module tb_dual_result_stage;
   localparam int W = 64;
   localparam int T = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         adv = 1'b0, in_valid = 1'b0, ack_lo = 1'b0, ack_hi = 1'b0;
   logic [T-1:0] tag_in = '0;
   logic [W-1:0] lo_in = '0, hi_in = '0;
   logic         cmp_lo, cmp_hi, stall;
   logic [T-1:0] tag_lo, tag_hi;
   logic [W-1:0] lo_out, hi_out;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dual_result_stage #(.WORD_W(W), .TAG_W(T)) dut (.*);

   // behavioural reference model
   logic         m_clo = 0, m_chi = 0;
   logic [W-1:0] m_lo = '0, m_hi = '0;
   logic [T-1:0] m_tag = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_clo = 0; m_chi = 0; m_lo = '0; m_hi = '0; m_tag = '0;
      end else begin
         if ((!m_clo || ack_lo) && (!m_chi || ack_hi) && adv) begin
            m_clo = in_valid; m_chi = in_valid;
            m_lo = lo_in; m_hi = hi_in; m_tag = tag_in;
         end else begin
            if (ack_lo) m_clo = 0;
            if (ack_hi) m_chi = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      logic m_stall;
      m_stall = (m_clo && !ack_lo) || (m_chi && !ack_hi);
      chk("R2/R4 cmp_lo", W'(cmp_lo), W'(m_clo));
      chk("R2/R7 cmp_hi", W'(cmp_hi), W'(m_chi));
      chk("R5 stall", W'(stall), W'(m_stall));
      chk("R6 lo_out", lo_out, m_lo);
      chk("R6 hi_out", hi_out, m_hi);
      chk("R2 tag_lo", W'(tag_lo), W'(m_tag));
      chk("R3 tag_hi", W'(tag_hi), W'(T'(m_tag + 1)));
   endtask

   task automatic drive(input logic a, input logic v, input logic [T-1:0] t,
                        input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic al, input logic ah);
      logic [2*W-1:0] prod;
      prod = x * y;   // stub double-width product
      adv = a; in_valid = v; tag_in = t; lo_in = prod[W-1:0]; hi_in = prod[2*W-1:W];
      ack_lo = al; ack_hi = ah;
   endtask

   // one cycle: drive after falling edge, check at next falling edge
   task automatic step(input logic a, input logic v, input logic [T-1:0] t,
                       input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic al, input logic ah);
      drive(a, v, t, x, y, al, ah);
      @(negedge clk);
      cmp_model();
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] keep_hi;
      @(negedge clk);
      // R1: reset state
      chk("R1 cmp_lo in reset", W'(cmp_lo), 0);
      chk("R1 cmp_hi in reset", W'(cmp_hi), 0);
      chk("R1 stall in reset", W'(stall), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after reset", W'({cmp_lo, cmp_hi, stall}), 0);

      // R3: tag 63 wraps to 0; R2 load
      step(1, 1, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0);
      chk("R2 cmp_lo set", W'(cmp_lo), 1);
      chk("R3 wrap tag_hi", W'(tag_hi), 0);
      chk("R5 stall while pending", W'(stall), 1);
      keep_hi = hi_out;
      // R6: offer new data while stalled
      step(1, 1, 6'd5, 64'd7, 64'd9, 0, 0);
      chk("R6 tag held", W'(tag_lo), 63);
      // R7: ack low only
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R7 lo cleared", W'(cmp_lo), 0);
      chk("R7 hi still pending", W'(cmp_hi), 1);
      chk("R7 hi word held", hi_out, keep_hi);
      // R9: stray ack on empty low port
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R9 stray ack no effect", W'({cmp_lo, cmp_hi}), 2'b01);
      // R8: last pending ack together with new load
      drive(1, 1, 6'd10, 64'd11, 64'd13, 0, 1);
      #0; chk("R8 no stall on draining ack", W'(stall), 0);
      @(negedge clk); cmp_model();
      chk("R8 new load both set", W'({cmp_lo, cmp_hi}), 2'b11);
      chk("R8 new tag", W'(tag_hi), 11);
      // R8: joint acks with load, back to back
      step(1, 1, 6'd20, 64'd2, 64'd4, 1, 1);
      chk("R8 back-to-back low word", lo_out, 64'd8);
      // R10: bubble
      step(1, 0, 6'd30, 64'd1, 64'd1, 1, 1);
      chk("R10 bubble flags", W'({cmp_lo, cmp_hi}), 0);
      // R4: ack high first
      step(1, 1, 6'd40, 64'd5, 64'd6, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1);
      chk("R4 only hi cleared", W'({cmp_lo, cmp_hi}), 2'b10);
      step(0, 0, 0, 0, 0, 1, 0);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) != 0),
              T'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule